// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Sequencer

This block sits behind a two-wire serial slave front end and in front of a byte-wide nonvolatile array model of 2048 bytes, split into 128 pages of 16 bytes. The front end has already decoded the bus. It hands over each received data byte with its full address and a flag saying whether the byte targets nonvolatile storage. The block gathers those bytes into a one-page staging buffer and keeps a pending bit for every byte slot that was actually received.

When the front end reports the bus STOP as a commit strobe, the block starts one self-timed programming cycle, but only if at least one byte is pending. The cycle lasts `CYCLE_CLKS` clocks. A busy flag stays high for all of it. At the end, only the pending bytes are copied into the array and the pending mask is cleared. While busy is high, new bytes, reads and commits are all ignored, which locks the bus out.

Outside a cycle, the block answers single-byte reads from the array with one clock of latency. The two reserved bytes near the top of the address space are never programmed and always read as zero.

Top module: `nvw_page_seq`

## Requirements
- R1: After reset, busy and rd_valid are 0 and every array byte reads as 00h.
- R2: A rd_req while busy is 0 gives rd_valid=1 on the next clock, with rd_data equal to the array byte at rd_addr.
- R3: Bytes that are staged but not yet committed do not change what a read returns.
- R4: A commit while idle with at least one pending byte makes busy go high on the next clock. Busy then stays high for exactly CYCLE_CLKS clocks. When busy falls, the array holds the committed bytes.
- R5: Only the byte slots received since the last cycle are programmed; the other bytes of that page keep their old values, and the pending mask is empty after the cycle.
- R6: The first accepted byte after an empty mask fixes the page (address bits 10..4). Later bytes whose address bits 10..4 differ from that page are dropped.
- R7: A byte presented with wr_nv=0 is not staged. A commit that follows only such bytes starts no cycle.
- R8: A commit while idle with nothing pending, and no byte accepted in the same clock, leaves busy at 0.
- R9: While busy is 1, wr_valid, rd_req and commit have no effect: rd_valid stays 0, and a byte offered then is neither programmed nor left pending.
- R10: Addresses 7FCh and 7FDh are reserved: writes to them are never staged, and reads of them return 00h.
- R11: A byte accepted in the same clock as the commit is part of that cycle.
- R12: Writing the same address twice before a commit programs the later value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | A received data byte is presented this clock |
| wr_nv | input | 1 | The presented byte targets nonvolatile storage |
| wr_addr | input | 11 | Full byte address of the presented byte |
| wr_data | input | 8 | Presented data byte |
| commit | input | 1 | Bus STOP strobe that ends a write |
| rd_req | input | 1 | Single-byte read request |
| rd_addr | input | 11 | Read address |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one clock after an accepted request |
| busy | output | 1 | Programming cycle in progress |

## Verification
The two functions that can land in the same clock are staging of a data byte and the commit that ends the write: the front end may deliver the final byte together with STOP. The bench provokes this by raising wr_valid and commit together, both directed and at random. This includes the case where that byte is the only one pending, so the launch decision has to take the byte arriving in that clock into account. The outcome is judged by checking that busy rises, that the cycle length is exact, and that the array reads back with the byte included.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
    localparam int unsigned DEF_MEM_BYTES  = 2048;
    localparam int unsigned DEF_PAGE_BYTES = 16;
    localparam int unsigned DEF_CYCLE_CLKS = 48;
    localparam int unsigned BYTE_W         = 8;
endpackage

// File: rtl/nvw_cycle_timer.sv
module nvw_cycle_timer #(
    parameter int unsigned CYCLE_CLKS = nvw_pkg::DEF_CYCLE_CLKS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int unsigned CNT_W = (CYCLE_CLKS > 1) ? $clog2(CYCLE_CLKS) : 1;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        done  = tmr_q.busy && (tmr_q.cnt == '0);
        if (tmr_q.busy) begin
            if (done) tmr_d.busy = 1'b0;
            else      tmr_d.cnt  = tmr_q.cnt - 1'b1;
        end else if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CNT_W'(CYCLE_CLKS - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = tmr_q.busy;

    // R4
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_q.busy) |-> $past(start));
    // R4
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.busy |-> (32'(tmr_q.cnt) < CYCLE_CLKS));
endmodule

// File: rtl/nvw_page_buf.sv
module nvw_page_buf #(
    parameter int unsigned MEM_BYTES  = nvw_pkg::DEF_MEM_BYTES,
    parameter int unsigned PAGE_BYTES = nvw_pkg::DEF_PAGE_BYTES,
    localparam int unsigned ADDR_W = $clog2(MEM_BYTES),
    localparam int unsigned OFS_W  = $clog2(PAGE_BYTES),
    localparam int unsigned PAGE_W = ADDR_W - OFS_W
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        accept,
    input  logic [ADDR_W-1:0]                           addr,
    input  logic [nvw_pkg::BYTE_W-1:0]                  data,
    input  logic                                        clr,
    output logic [PAGE_BYTES-1:0]                       mask,
    output logic [PAGE_W-1:0]                           page,
    output logic [PAGE_BYTES-1:0][nvw_pkg::BYTE_W-1:0]  bytes
);
    typedef struct packed {
        logic [PAGE_W-1:0]                          page;
        logic [PAGE_BYTES-1:0]                      mask;
        logic [PAGE_BYTES-1:0][nvw_pkg::BYTE_W-1:0] data;
    } buf_s;

    buf_s buf_d, buf_q;
    logic [OFS_W-1:0]  ofs;
    logic [PAGE_W-1:0] in_page;

    assign ofs     = addr[OFS_W-1:0];
    assign in_page = addr[ADDR_W-1:OFS_W];

    always_comb begin
        buf_d = buf_q;
        if (clr) begin
            buf_d.mask = '0;
        end else if (accept) begin
            if (buf_q.mask == '0) begin
                buf_d.page      = in_page;
                buf_d.mask      = '0;
                buf_d.mask[ofs] = 1'b1;
                buf_d.data[ofs] = data;
            end else if (in_page == buf_q.page) begin
                buf_d.mask[ofs] = 1'b1;
                buf_d.data[ofs] = data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign mask  = buf_q.mask;
    assign page  = buf_q.page;
    assign bytes = buf_q.data;

    // R5
    mask_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (buf_q.mask == '0));
    // R6
    page_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((buf_q.mask != '0) && !clr) |=> $stable(buf_q.page));
endmodule

// File: rtl/nvw_mem_array.sv
module nvw_mem_array #(
    parameter int unsigned MEM_BYTES  = nvw_pkg::DEF_MEM_BYTES,
    parameter int unsigned PAGE_BYTES = nvw_pkg::DEF_PAGE_BYTES,
    localparam int unsigned ADDR_W = $clog2(MEM_BYTES),
    localparam int unsigned OFS_W  = $clog2(PAGE_BYTES),
    localparam int unsigned PAGE_W = ADDR_W - OFS_W
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        prog_en,
    input  logic [PAGE_W-1:0]                           prog_page,
    input  logic [PAGE_BYTES-1:0]                       prog_mask,
    input  logic [PAGE_BYTES-1:0][nvw_pkg::BYTE_W-1:0]  prog_data,
    input  logic                                        rd_en,
    input  logic                                        rd_zero,
    input  logic [ADDR_W-1:0]                           rd_addr,
    output logic [nvw_pkg::BYTE_W-1:0]                  rd_data,
    output logic                                        rd_valid
);
    logic [nvw_pkg::BYTE_W-1:0] mem_q [MEM_BYTES];
    logic [nvw_pkg::BYTE_W-1:0] rd_data_q;
    logic                       rd_valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(MEM_BYTES); i++) mem_q[i] <= '0;
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            if (prog_en) begin
                for (int l = 0; l < int'(PAGE_BYTES); l++) begin
                    if (prog_mask[l]) mem_q[{prog_page, OFS_W'(l)}] <= prog_data[l];
                end
            end
            rd_valid_q <= rd_en;
            if (rd_en) rd_data_q <= rd_zero ? '0 : mem_q[rd_addr];
        end
    end

    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;

    // R2
    rd_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_q |-> $past(rd_en));
    // R2
    no_read_during_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_en && rd_en));
endmodule

// File: rtl/nvw_page_seq.sv
module nvw_page_seq #(
    parameter int unsigned MEM_BYTES  = nvw_pkg::DEF_MEM_BYTES,
    parameter int unsigned PAGE_BYTES = nvw_pkg::DEF_PAGE_BYTES,
    parameter int unsigned CYCLE_CLKS = nvw_pkg::DEF_CYCLE_CLKS,
    localparam int unsigned ADDR_W = $clog2(MEM_BYTES),
    localparam int unsigned OFS_W  = $clog2(PAGE_BYTES),
    localparam int unsigned PAGE_W = ADDR_W - OFS_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  logic                       wr_nv,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [nvw_pkg::BYTE_W-1:0] wr_data,
    input  logic                       commit,
    input  logic                       rd_req,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [nvw_pkg::BYTE_W-1:0] rd_data,
    output logic                       rd_valid,
    output logic                       busy
);
    localparam logic [ADDR_W-1:0] RSV_LO = ADDR_W'(MEM_BYTES - 4);
    localparam logic [ADDR_W-1:0] RSV_HI = ADDR_W'(MEM_BYTES - 3);

    logic                                       wr_rsv, rd_rsv, accept, launch, done, rd_en;
    logic [PAGE_BYTES-1:0]                      pend_mask;
    logic [PAGE_W-1:0]                          pend_page;
    logic [PAGE_BYTES-1:0][nvw_pkg::BYTE_W-1:0] pend_bytes;

    assign wr_rsv = (wr_addr == RSV_LO) || (wr_addr == RSV_HI);
    assign rd_rsv = (rd_addr == RSV_LO) || (rd_addr == RSV_HI);
    assign accept = wr_valid && wr_nv && !busy && !wr_rsv;
    assign launch = commit && !busy && ((pend_mask != '0) || accept);
    assign rd_en  = rd_req && !busy;

    nvw_page_buf #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) buf_i (
        .clk(clk), .rst_n(rst_n), .accept(accept), .addr(wr_addr), .data(wr_data),
        .clr(done), .mask(pend_mask), .page(pend_page), .bytes(pend_bytes));

    nvw_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) tmr_i (
        .clk(clk), .rst_n(rst_n), .start(launch), .busy(busy), .done(done));

    nvw_mem_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) mem_i (
        .clk(clk), .rst_n(rst_n), .prog_en(done), .prog_page(pend_page),
        .prog_mask(pend_mask), .prog_data(pend_bytes), .rd_en(rd_en),
        .rd_zero(rd_rsv), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid));

    // R8
    empty_commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !busy && (pend_mask == '0) && !accept) |=> !busy);
    // R9
    locked_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(pend_mask));
    // R9
    no_read_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !$past(busy));
    // R10
    rsv_never_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_page == {PAGE_W{1'b1}}) |-> (pend_mask[OFS_W'(RSV_LO)] == 1'b0 && pend_mask[OFS_W'(RSV_HI)] == 1'b0));
endmodule

// File: tb/nvw_page_seq_tb.sv
module nvw_page_seq_tb_top;
    localparam int CYC = 48;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       wr_valid = 0, wr_nv = 0, commit = 0, rd_req = 0;
    logic [10:0] wr_addr = '0, rd_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        rd_valid, busy;

    int total = 0, bad = 0;
    bit fin = 0;

    logic [7:0]  exp_mem [2048];
    logic [15:0] m_mask = '0;
    logic [6:0]  m_page = '0;
    logic [7:0]  m_data [16];

    always #4 clk = ~clk;

    nvw_page_seq #(.CYCLE_CLKS(CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_nv(wr_nv), .wr_addr(wr_addr),
        .wr_data(wr_data), .commit(commit), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy));

    function automatic bit is_rsv(input logic [10:0] a);
        return (a == 11'h7FC) || (a == 11'h7FD);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void model_put(input logic [10:0] a, input logic [7:0] d, input bit nv);
        if (!nv || is_rsv(a)) return;
        if (m_mask == '0) begin m_page = a[10:4]; m_mask[a[3:0]] = 1'b1; m_data[a[3:0]] = d; end
        else if (a[10:4] == m_page) begin m_mask[a[3:0]] = 1'b1; m_data[a[3:0]] = d; end
    endfunction

    // evaluate state right after a commit edge
    task automatic after_commit(input string tag);
        int n;
        if (m_mask != '0) begin
            chk(busy === 1'b1, {tag, " R4 busy rise"}, busy, 1);
            n = 0;
            while (busy === 1'b1 && n < 10 * CYC) begin n++; @(negedge clk); end
            chk(n == CYC, {tag, " R4 busy length"}, n, CYC);
            for (int l = 0; l < 16; l++) if (m_mask[l]) exp_mem[{m_page, 4'(l)}] = m_data[l];
            m_mask = '0;
        end else begin
            chk(busy === 1'b0, {tag, " R8 no cycle"}, busy, 0);
        end
    endtask

    task automatic put(input logic [10:0] a, input logic [7:0] d, input bit nv, input bit cm, input string tag);
        wr_valid = 1; wr_addr = a; wr_data = d; wr_nv = nv; commit = cm;
        model_put(a, d, nv);
        @(negedge clk);
        wr_valid = 0; commit = 0; wr_nv = 0;
        if (cm) after_commit(tag);
    endtask

    task automatic do_commit(input string tag);
        commit = 1;
        @(negedge clk);
        commit = 0;
        after_commit(tag);
    endtask

    task automatic rd(input logic [10:0] a, input string tag);
        rd_req = 1; rd_addr = a;
        @(negedge clk);
        rd_req = 0;
        chk(rd_valid === 1'b1, {tag, " R2 rd_valid"}, rd_valid, 1);
        chk(rd_data === exp_mem[a], tag, rd_data, exp_mem[a]);
    endtask

    initial begin : watchdog
        int c = 0;
        while (!fin) begin
            @(posedge clk);
            c++;
            if (c > 150000) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected=%0d", c, 150000);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin : main
        void'($urandom(32'h1C3A));
        for (int i = 0; i < 2048; i++) exp_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0, "R1 busy", busy, 0);
        chk(rd_valid === 1'b0, "R1 rd_valid", rd_valid, 0);
        rd(11'h000, "R1 read 000");
        rd(11'h7FF, "R1 read 7FF");

        // R8 empty commit
        do_commit("R8 empty");

        // R3 staged not visible, R12 last wins, R5 partial page
        put(11'h120, 8'hAA, 1, 0, "R12");
        put(11'h123, 8'h11, 1, 0, "R12");
        put(11'h123, 8'h22, 1, 0, "R12");
        rd(11'h123, "R3 staged invisible");
        do_commit("R5");
        rd(11'h123, "R12 later value");
        rd(11'h120, "R5 written");
        rd(11'h121, "R5 untouched");

        // R6 other page dropped
        put(11'h200, 8'h5A, 1, 0, "R6");
        put(11'h213, 8'hC3, 1, 0, "R6");
        do_commit("R6");
        rd(11'h213, "R6 dropped byte");
        rd(11'h200, "R6 kept byte");

        // R7 volatile-only bytes
        put(11'h7FF, 8'h33, 0, 0, "R7");
        do_commit("R7 no cycle");
        rd(11'h7FF, "R7 not written");

        // R10 reserved
        put(11'h7FC, 8'hEE, 1, 0, "R10");
        do_commit("R10 no cycle");
        rd(11'h7FC, "R10 reserved read");
        put(11'h7FC, 8'hEE, 1, 0, "R10");
        put(11'h7FE, 8'h80, 1, 0, "R10");
        do_commit("R10 page 7F");
        rd(11'h7FC, "R10 reserved after cycle");
        rd(11'h7FE, "R10 neighbour written");

        // R11 sole byte arrives with commit
        put(11'h355, 8'h9D, 1, 1, "R11");
        rd(11'h355, "R11 same-clock byte");

        // R9 lockout during busy
        put(11'h400, 8'h01, 1, 0, "R9");
        commit = 1; @(negedge clk); commit = 0;
        chk(busy === 1'b1, "R9 busy", busy, 1);
        wr_valid = 1; wr_nv = 1; wr_addr = 11'h401; wr_data = 8'h77;
        rd_req = 1; rd_addr = 11'h400; commit = 1;
        @(negedge clk);
        wr_valid = 0; wr_nv = 0; rd_req = 0; commit = 0;
        chk(rd_valid === 1'b0, "R9 read ignored", rd_valid, 0);
        begin : r9_rest
            int n = 2;
            while (busy === 1'b1 && n < 10 * CYC) begin n++; @(negedge clk); end
            chk(n == CYC + 1, "R9 cycle not restarted", n, CYC + 1);
        end
        exp_mem[11'h400] = 8'h01; m_mask = '0;
        do_commit("R9 nothing left pending");
        rd(11'h401, "R9 byte dropped");
        rd(11'h400, "R9 cycle byte");

        // random phase
        for (int it = 0; it < 40; it++) begin
            logic [6:0] pg;
            int nb;
            pg = 7'($urandom_range(0, 127));
            nb = $urandom_range(1, 16);
            for (int b = 0; b < nb; b++) begin
                logic [10:0] a;
                bit nv, last;
                a = {pg, 4'($urandom_range(0, 15))};
                if ($urandom_range(0, 7) == 0) a = {pg + 7'd1, a[3:0]};
                nv = ($urandom_range(0, 9) != 0);
                last = (b == nb - 1) && ($urandom_range(0, 1) == 1);
                put(a, 8'($urandom), nv, last, "R11 random");
                if (last) break;
            end
            if (m_mask != '0 || $urandom_range(0, 1) == 1) do_commit("R4 random");
            if (m_mask != '0) do_commit("R4 random");
            for (int k = 0; k < 4; k++) rd({pg, 4'($urandom_range(0, 15))}, "R5 random readback");
        end

        fin = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule